// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block guards loads that the compiler has scheduled ahead of stores whose addresses were unknown at compile time. When such a hoisted load issues, the tracker records its destination register and the 8-byte line it read. Every store that later retires is compared against all recorded lines in the same cycle, and every entry it hits is dropped. When the program reaches the point where the load used to sit, a check names the destination register. The tracker reports either that the early value is still good, or what recovery the core must perform.

Two kinds of check exist. A light check is used when only the load itself was moved early, and a failure asks for the value to be loaded again. A full check is used when other speculative work already consumed the value, and a failure asks for a branch to recovery code that replays that work. A passing check retires the entry. Missing entries, whether evicted, never made, or already consumed, count as failures. Memory access and the replay itself happen outside this block.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset the table holds no entries and all response outputs are 0; any check issued right after reset fails.
- R2: An advanced load (`ld_valid`) records `ld_reg` and `ld_addr`; a later check of that register, with no intervening conflicting store, reports `rsp_pass`.
- R3: A check issued in cycle t is answered in cycle t+1 with `rsp_valid`=1 and exactly one of `rsp_pass`, `rsp_reload`, `rsp_fixup` high; without a check all four outputs are 0.
- R4: A store invalidates an entry when `st_addr[63:3]` equals the entry's `ld_addr[63:3]`; bits [2:0] are ignored, and a difference in any of bits [63:3] leaves the entry intact.
- R5: One store invalidates every entry with a matching line in the same cycle, whatever the number of such entries.
- R6: A failing check with `chk_full`=0 reports `rsp_reload`.
- R7: A failing check with `chk_full`=1 reports `rsp_fixup`.
- R8: A check of a register that has no valid entry fails.
- R9: A passing check removes the entry, so a second check of the same register with no new load in between fails.
- R10: An advanced load to a register that already has a valid entry replaces that entry's address and makes it the youngest entry.
- R11: The table holds 16 entries; a new register goes into a free entry if one exists, otherwise it evicts the entry that was written least recently.
- R12: A store and an advanced load in the same cycle: the store is compared first, so the new entry survives even if the addresses match.
- R13: A check in the same cycle as a store sees the store's invalidation; a check in the same cycle as a load to the same register sees the table before that load, and the load's entry remains afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | An advanced load issues this cycle |
| ld_reg | input | 7 | Destination register of the advanced load |
| ld_addr | input | 64 | Byte address read by the advanced load |
| st_valid | input | 1 | A store executes this cycle |
| st_addr | input | 64 | Byte address written by the store |
| chk_valid | input | 1 | A check is issued this cycle |
| chk_reg | input | 7 | Register named by the check |
| chk_full | input | 1 | 1 = full check (fix-up on failure), 0 = light check (reload on failure) |
| rsp_valid | output | 1 | Response to the previous cycle's check |
| rsp_pass | output | 1 | The speculative value is still good |
| rsp_reload | output | 1 | Failed light check: load the value again |
| rsp_fixup | output | 1 | Failed full check: branch to recovery code |

## Verification
The hardest state to reach from the ports is a full table whose eviction order has been reshuffled by replacing loads, because the oldest entry is never visible directly and shows itself only when a seventeenth register pushes it out and a later check fails. The stimulus fills the table with sixteen distinct registers, refreshes one of them, and then adds further registers and checks every survivor. Same-cycle collisions of store, load and check are driven one by one, and a long pseudo-random run over a narrow register and line range keeps the table full and full of aliased lines against a timestamp model kept in the bench.

// File: rtl/sltrk_pkg.sv
package sltrk_pkg;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_PASS   = 2'd1,
        RSP_RELOAD = 2'd2,
        RSP_FIXUP  = 2'd3
    } rsp_e;

endpackage

// File: rtl/sltrk_cam.sv
// Parallel comparators: every entry is compared against the store line,
// the load register and the check register in one cycle.
module sltrk_cam #(
    parameter int N      = 16,
    parameter int REG_W  = 7,
    parameter int LINE_W = 61
) (
    input  logic [N-1:0][REG_W-1:0]  tag,
    input  logic [N-1:0][LINE_W-1:0] line,
    input  logic [LINE_W-1:0]        st_line,
    input  logic [REG_W-1:0]         ld_reg,
    input  logic [REG_W-1:0]         chk_reg,
    output logic [N-1:0]             st_eq,
    output logic [N-1:0]             ld_eq,
    output logic [N-1:0]             chk_eq
);

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign st_eq[i]  = (line[i] == st_line);
        assign ld_eq[i]  = (tag[i] == ld_reg);
        assign chk_eq[i] = (tag[i] == chk_reg);
    end

endmodule

// File: rtl/sltrk_victim.sv
// Picks the slot for a new entry: same register first, then the lowest
// free slot, then the slot with the highest age rank (least recent write).
module sltrk_victim #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0]            same,
    input  logic [N-1:0][IDX_W-1:0] rank,
    output logic [IDX_W-1:0]        idx
);

    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        same_idx = '0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same[i])                          same_idx = IDX_W'(i);
            if (!vld[i])                          free_idx = IDX_W'(i);
            if (rank[i] == IDX_W'(N - 1))         old_idx  = IDX_W'(i);
        end
        if (|same)       idx = same_idx;
        else if (~&vld)  idx = free_idx;
        else             idx = old_idx;
    end

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
    import sltrk_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int REG_W    = 7,
    parameter int ADDR_W   = 64,
    parameter int LINE_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_full,
    output logic              rsp_valid,
    output logic              rsp_pass,
    output logic              rsp_reload,
    output logic              rsp_fixup
);

    localparam int LINE_W = ADDR_W - LINE_LSB;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]              vld;
        logic [ENTRIES-1:0][REG_W-1:0]   tag;
        logic [ENTRIES-1:0][LINE_W-1:0]  line;
        logic [ENTRIES-1:0][IDX_W-1:0]   rank;
        rsp_e                            rsp;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0] st_eq, ld_eq, chk_eq;
    logic [ENTRIES-1:0] st_kill, vld_a, chk_hit, vld_b;
    logic [IDX_W-1:0]   slot;
    logic               unused_low;

    assign unused_low = ^{st_addr[LINE_LSB-1:0], ld_addr[LINE_LSB-1:0]};

    sltrk_cam #(
        .N      (ENTRIES),
        .REG_W  (REG_W),
        .LINE_W (LINE_W)
    ) u_cam (
        .tag     (s_q.tag),
        .line    (s_q.line),
        .st_line (st_addr[ADDR_W-1:LINE_LSB]),
        .ld_reg  (ld_reg),
        .chk_reg (chk_reg),
        .st_eq   (st_eq),
        .ld_eq   (ld_eq),
        .chk_eq  (chk_eq)
    );

    // program order inside one cycle: store, then check, then load
    assign st_kill = st_valid  ? (s_q.vld & st_eq) : '0;
    assign vld_a   = s_q.vld & ~st_kill;
    assign chk_hit = chk_valid ? (vld_a & chk_eq) : '0;
    assign vld_b   = vld_a & ~chk_hit;

    sltrk_victim #(
        .N     (ENTRIES),
        .IDX_W (IDX_W)
    ) u_victim (
        .vld  (vld_b),
        .same (vld_b & ld_eq),
        .rank (s_q.rank),
        .idx  (slot)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = vld_b;

        if (!chk_valid)     s_d.rsp = RSP_NONE;
        else if (|chk_hit)  s_d.rsp = RSP_PASS;
        else if (chk_full)  s_d.rsp = RSP_FIXUP;
        else                s_d.rsp = RSP_RELOAD;

        if (ld_valid) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (s_q.rank[j] < s_q.rank[slot]) s_d.rank[j] = s_q.rank[j] + 1'b1;
            end
            s_d.rank[slot] = '0;
            s_d.vld[slot]  = 1'b1;
            s_d.tag[slot]  = ld_reg;
            s_d.line[slot] = ld_addr[ADDR_W-1:LINE_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.vld  <= '0;
            s_q.tag  <= '0;
            s_q.line <= '0;
            s_q.rsp  <= RSP_NONE;
            for (int i = 0; i < ENTRIES; i++) s_q.rank[i] <= IDX_W'(i);
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid  = (s_q.rsp != RSP_NONE);
    assign rsp_pass   = (s_q.rsp == RSP_PASS);
    assign rsp_reload = (s_q.rsp == RSP_RELOAD);
    assign rsp_fixup  = (s_q.rsp == RSP_FIXUP);

endmodule

// File: rtl/sltrk_checker.sv
module sltrk_checker #(
    parameter int REG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic [REG_W-1:0] ld_reg,
    input logic             chk_valid,
    input logic [REG_W-1:0] chk_reg,
    input logic             chk_full,
    input logic             rsp_valid,
    input logic             rsp_pass,
    input logic             rsp_reload,
    input logic             rsp_fixup
);

    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_pass, rsp_reload, rsp_fixup}) == 1);

    assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $countones({rsp_pass, rsp_reload, rsp_fixup}) == 0);

    assert_answer_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> rsp_valid);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(chk_valid));

    assert_reload_light_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reload |-> !$past(chk_full));

    assert_fixup_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fixup |-> $past(chk_full));

    assert_pass_consumes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && rsp_pass && chk_reg == $past(chk_reg)
         && !($past(ld_valid) && $past(ld_reg) == chk_reg))
        |=> (rsp_valid && !rsp_pass));

endmodule

bind spec_load_tracker sltrk_checker #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_reg     (ld_reg),
    .chk_valid  (chk_valid),
    .chk_reg    (chk_reg),
    .chk_full   (chk_full),
    .rsp_valid  (rsp_valid),
    .rsp_pass   (rsp_pass),
    .rsp_reload (rsp_reload),
    .rsp_fixup  (rsp_fixup)
);

// File: tb/sim_spec_load_tracker.sv
module sim_spec_load_tracker;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [6:0]  ld_reg = '0;
    logic [63:0] ld_addr = '0;
    logic        st_valid = 1'b0;
    logic [63:0] st_addr = '0;
    logic        chk_valid = 1'b0;
    logic [6:0]  chk_reg = '0;
    logic        chk_full = 1'b0;
    logic        rsp_valid, rsp_pass, rsp_reload, rsp_fixup;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model: valid, register, line, write stamp
    bit          m_vld [N];
    int          m_tag [N];
    logic [60:0] m_line[N];
    int          m_stamp[N];
    int          stamp_cnt;

    always #2 clk = ~clk;

    spec_load_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_full(chk_full),
        .rsp_valid(rsp_valid), .rsp_pass(rsp_pass),
        .rsp_reload(rsp_reload), .rsp_fixup(rsp_fixup)
    );

    task automatic expect4(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,pass,reload,fixup} = %b, expected %b", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = 0; m_line[i] = '0; m_stamp[i] = -i;
        end
        stamp_cnt = 1;
    endtask

    // one cycle; order inside the cycle: store, check, load
    task automatic op(input bit l, input int lreg, input logic [63:0] la,
                      input bit s, input logic [63:0] sa,
                      input bit c, input int creg, input bit cf, input string tag);
        logic [3:0] exp;
        bit pass;
        int k;
        @(negedge clk);
        ld_valid = l;  ld_reg = 7'(lreg);  ld_addr = la;
        st_valid = s;  st_addr = sa;
        chk_valid = c; chk_reg = 7'(creg); chk_full = cf;
        if (s) for (int i = 0; i < N; i++)
            if (m_vld[i] && m_line[i] == sa[63:3]) m_vld[i] = 1'b0;
        pass = 1'b0;
        if (c) for (int i = 0; i < N; i++)
            if (m_vld[i] && m_tag[i] == creg) begin pass = 1'b1; m_vld[i] = 1'b0; end
        if (l) begin
            k = -1;
            for (int i = 0; i < N; i++) if (k < 0 && m_vld[i] && m_tag[i] == lreg) k = i;
            for (int i = 0; i < N; i++) if (k < 0 && !m_vld[i]) k = i;
            if (k < 0) begin
                k = 0;
                for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[k]) k = i;
            end
            m_vld[k] = 1'b1; m_tag[k] = lreg; m_line[k] = la[63:3];
            m_stamp[k] = stamp_cnt; stamp_cnt++;
        end
        exp = !c ? 4'b0000 : pass ? 4'b1100 : cf ? 4'b1001 : 4'b1010;
        @(posedge clk); #1;
        if (c) expect4(tag, {rsp_valid, rsp_pass, rsp_reload, rsp_fixup}, exp);
        @(negedge clk);
        ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    endtask

    task automatic load(input int r, input logic [63:0] a);
        op(1, r, a, 0, '0, 0, 0, 0, "");
    endtask
    task automatic store(input logic [63:0] a);
        op(0, 0, '0, 1, a, 0, 0, 0, "");
    endtask
    task automatic check(input int r, input bit f, input string tag);
        op(0, 0, '0, 0, '0, 1, r, f, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] a;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: idle outputs after reset
        expect4("R1", {rsp_valid, rsp_pass, rsp_reload, rsp_fixup}, 4'b0000);
        // R1, R8, R6: empty table, every check fails with reload
        for (int r = 0; r < 16; r++) check(r * 8, 0, "R1");

        // R2: sixteen loads, all pass; R9, R7: second check fails with fixup
        for (int r = 0; r < 16; r++) load(r * 8 + 1, 64'h1000 + r * 64);
        for (int r = 0; r < 16; r++) check(r * 8 + 1, 0, "R2");
        for (int r = 0; r < 16; r++) check(r * 8 + 1, 1, "R9");

        // R4: every byte inside the line kills, neighbours and high bit do not
        for (int k = 0; k < 8; k++) begin
            load(5, 64'h0000_00AB_CDEF_0040);
            store(64'h0000_00AB_CDEF_0040 + k);
            check(5, k[0], "R4");
        end
        load(6, 64'h0000_00AB_CDEF_0040);
        store(64'h0000_00AB_CDEF_0048);
        store(64'h0000_00AB_CDEF_0038);
        store(64'h8000_00AB_CDEF_0040);
        check(6, 0, "R4");

        // R5: one store drops three aliased entries, a fourth survives
        load(10, 64'h2000); load(11, 64'h2003); load(12, 64'h2007); load(13, 64'h2008);
        store(64'h2004);
        check(10, 0, "R5"); check(11, 1, "R5"); check(12, 0, "R5"); check(13, 0, "R5");

        // R10: replacing a register moves its address
        load(20, 64'h3000); load(20, 64'h3100);
        store(64'h3000);
        check(20, 0, "R10");
        load(20, 64'h3100); store(64'h3100);
        check(20, 1, "R10");

        // R11: sixteen fresh registers, then a seventeenth evicts the oldest
        for (int r = 0; r < 16; r++) load(100 + r, 64'h9000 + r * 8);
        load(101, 64'h9800);             // R10: refresh age of 101
        load(116, 64'h9900);             // evicts 100
        load(117, 64'h9A00);             // evicts 102, not 101
        check(100, 0, "R11");
        check(102, 1, "R11");
        check(101, 0, "R11");
        for (int r = 103; r < 118; r++) check(r, 0, "R11");

        // R12: store and load with the same address in one cycle
        op(1, 30, 64'h5000, 1, 64'h5000, 0, 0, 0, "");
        check(30, 0, "R12");
        // R13: store and check in one cycle
        load(31, 64'h5100);
        op(0, 0, '0, 1, 64'h5100, 1, 31, 1, "R13");
        // R13: check and reload of the same register in one cycle
        load(32, 64'h5200);
        op(1, 32, 64'h5300, 0, '0, 1, 32, 0, "R13");
        check(32, 0, "R13");

        // pseudo-random run over few registers and lines
        for (int n = 0; n < 4000; n++) begin
            a = 64'h4000 + 64'(($urandom % 8) * 8) + 64'($urandom % 8);
            op($urandom % 2 == 0, int'($urandom % 24), a,
               $urandom % 10 < 3, 64'h4000 + 64'(($urandom % 8) * 8) + 64'($urandom % 8),
               $urandom % 2 == 0, int'($urandom % 24), $urandom % 2 == 1, "R11");
        end

        // R1: reset clears the table
        load(40, 64'h7000);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        model_reset();
        check(40, 0, "R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule